// File: doc/BRIEF.md
# Multithreaded Delay-Slot Fetch Sequencer

This block hands out instruction fetch addresses for several hardware threads. Each thread keeps a window of three addresses: the address to fetch now, the one after it, and the one after that. Every granted fetch returns an address and a per-thread sequence number, then moves the window forward. Branches with one architectural delay slot are tracked by a countdown. The slot instruction is still fetched in order, and the stored target takes over on the grant that follows.

Control updates arrive from a later pipeline stage. A return that was not predicted taken stops the thread, and the block raises a block request to the stage that reported it. A predicted-taken branch, or a conditional delay-slot branch predicted not taken, asks for a squash of younger work. Squash redirects come in on several lanes in the same cycle. For each thread only the oldest of them is kept; it reloads the window and releases a stalled thread. Separate activate and deactivate inputs start a thread at a given address or park it.

Top module: `fetch_seq`

## Requirements
- R1: An activate loads the thread's window from the given address A and marks it valid; the next three grants of that thread return A, A+4 and A+8.
- R2: A grant with no pending redirect returns the current address and moves the window one step, so consecutive grants differ by 4 bytes; address arithmetic wraps modulo 2^32 (0xFFFFFFFC is followed by 0x0).
- R3: A fetch request to a thread whose valid flag is clear gets fetch_gnt_o low, and that thread's sequence number does not advance.
- R4: Each thread has its own sequence counter, starting at 0 after reset. It is returned on fetch_seq_o with each grant and advances by one only on a grant for that thread.
- R5: A taken control update, or a not-taken control update with ctl_is_cond_ds_i low, arms one delay slot. The next grant returns the sequential address, and the grant after it returns the target. The target is ctl_target_i when taken and ctl_pc_i+8 when not taken. A taken update also raises csq_valid_o with csq_seq_o = ctl_seq_i+1.
- R6: A control update with ctl_is_ret_i high and ctl_pred_taken_i low raises blk_valid_o with blk_stage_o = ctl_stage_i in the same cycle and clears the thread's valid flag, so later requests stall.
- R7: A control update with ctl_is_cond_ds_i high that is predicted not taken raises csq_valid_o with csq_seq_o = ctl_seq_i and leaves the fetch window unchanged.
- R8: An update with ctl_is_ctrl_i low has no effect: it raises no block and no squash request and does not change later fetch addresses.
- R9: Among the squash lanes valid for one thread in a cycle, the one with the smallest sequence number is accepted; on equal numbers the lowest lane index wins. Threads are arbitrated independently.
- R10: An accepted squash with address P clears the delay-slot state, reloads the window so the next grants return P, P+4, and sets the valid flag. If the flag was clear, unblk_o[t] pulses in that cycle with unblk_stage_o[t] equal to the recorded blocking stage.
- R11: A deactivate clears the valid flag, the delay-slot state and the recorded blocking stage (to 0); a pending delay slot does not redirect after a later activate.
- R12: After reset every thread is invalid: no request is granted, and blk_valid_o, csq_valid_o and unblk_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request |
| fetch_tid_i | input | TID_W | Requesting thread |
| fetch_gnt_o | output | 1 | Request granted this cycle |
| fetch_pc_o | output | ADDR_W | Granted fetch address |
| fetch_seq_o | output | SEQ_W | Sequence number of the grant |
| ctl_valid_i | input | 1 | Control update valid |
| ctl_tid_i | input | TID_W | Thread of the update |
| ctl_is_ctrl_i | input | 1 | Instruction is a control transfer |
| ctl_is_ret_i | input | 1 | Instruction is a return |
| ctl_is_cond_ds_i | input | 1 | Conditional branch with a delay slot |
| ctl_pred_taken_i | input | 1 | Predicted taken |
| ctl_pc_i | input | ADDR_W | Address of the control instruction |
| ctl_target_i | input | ADDR_W | Predicted target |
| ctl_seq_i | input | SEQ_W | Sequence number of the control instruction |
| ctl_stage_i | input | STAGE_W | Stage that reports the update |
| blk_valid_o | output | 1 | Block request to a stage |
| blk_tid_o | output | TID_W | Thread of the block |
| blk_stage_o | output | STAGE_W | Stage to block |
| csq_valid_o | output | 1 | Squash-younger request |
| csq_tid_o | output | TID_W | Thread to squash |
| csq_seq_o | output | SEQ_W | Squash everything younger than this number |
| sq_valid_i | input | N_SQ | Squash lane valid |
| sq_tid_i | input | N_SQ*TID_W | Thread per lane |
| sq_seq_i | input | N_SQ*SEQ_W | Sequence number per lane |
| sq_pc_i | input | N_SQ*ADDR_W | Redirect address per lane |
| unblk_o | output | N_THREADS | Unblock pulse per thread |
| unblk_stage_o | output | N_THREADS*STAGE_W | Stage to unblock per thread |
| act_valid_i | input | 1 | Activate a thread |
| act_tid_i | input | TID_W | Thread to activate |
| act_pc_i | input | ADDR_W | Start address |
| deact_valid_i | input | 1 | Deactivate a thread |
| deact_tid_i | input | TID_W | Thread to deactivate |

## Verification
Plain back-to-back fetches on one thread show the window step, and interleaved fetches on two threads show that the windows and counters are kept apart. A taken branch and a not-taken unconditional branch are both followed by two fetches: the first shows that the slot is still fetched in order, and the second tells a taken target from the fall-through target at ctl_pc_i+8. Two squash lanes hitting one thread with different numbers, then with equal numbers, tell oldest-first from lane-order selection. Squashing a stalled thread and then a running one tells the unblock pulse from its absence. Deactivating a thread with an armed delay slot and then reactivating it shows that the stale redirect is dropped.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  // effect of one control update on its thread
  typedef enum logic [1:0] {
    CK_NONE,   // nothing to do
    CK_STALL,  // unresolved return: park thread
    CK_SKIP,   // not-taken conditional: squash younger, no slot
    CK_DELAY   // arm delay slot, redirect afterwards
  } ctl_kind_e;
endpackage

// File: rtl/fseq_ctl_dec.sv
module fseq_ctl_dec
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEQ_W      = 16,
  parameter int INST_BYTES = 4
) (
  input  logic              valid_i,
  input  logic              is_ctrl_i,
  input  logic              is_ret_i,
  input  logic              is_cond_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [SEQ_W-1:0]  seq_i,
  output ctl_kind_e         kind_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              csq_o,
  output logic [SEQ_W-1:0]  csq_seq_o
);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INST_BYTES);

  always_comb begin
    kind_o    = CK_NONE;
    tgt_o     = target_i;
    csq_o     = 1'b0;
    csq_seq_o = seq_i;
    if (valid_i && is_ctrl_i) begin
      if (is_ret_i && !taken_i) begin
        kind_o = CK_STALL;
      end else if (is_cond_i && !taken_i) begin
        kind_o = CK_SKIP;
        csq_o  = 1'b1;
      end else if (!taken_i) begin
        kind_o = CK_DELAY;
        tgt_o  = pc_i + STEP2;
      end else begin
        kind_o    = CK_DELAY;
        csq_o     = 1'b1;
        csq_seq_o = seq_i + SEQ_W'(1);  // keep the slot instruction
      end
    end
  end
endmodule

// File: rtl/fseq_sq_arb.sv
module fseq_sq_arb #(
  parameter int N_SQ   = 2,
  parameter int TID_W  = 1,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int THREAD = 0
) (
  input  logic [N_SQ-1:0]        sq_valid_i,
  input  logic [N_SQ*TID_W-1:0]  sq_tid_i,
  input  logic [N_SQ*SEQ_W-1:0]  sq_seq_i,
  input  logic [N_SQ*ADDR_W-1:0] sq_pc_i,
  output logic                   acc_o,
  output logic [ADDR_W-1:0]      pc_o
);
  logic [SEQ_W-1:0] best_seq;

  // oldest lane wins; strict compare keeps the lowest lane on ties
  always_comb begin
    acc_o    = 1'b0;
    pc_o     = '0;
    best_seq = '0;
    for (int l = 0; l < N_SQ; l++) begin
      if (sq_valid_i[l] && sq_tid_i[l*TID_W +: TID_W] == TID_W'(THREAD) &&
          (!acc_o || sq_seq_i[l*SEQ_W +: SEQ_W] < best_seq)) begin
        acc_o    = 1'b1;
        best_seq = sq_seq_i[l*SEQ_W +: SEQ_W];
        pc_o     = sq_pc_i[l*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/fseq_thread.sv
module fseq_thread #(
  parameter int ADDR_W     = 32,
  parameter int SEQ_W      = 16,
  parameter int STAGE_W    = 3,
  parameter int CNT_W      = 2,
  parameter int INST_BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gnt_i,
  input  logic               ds_set_i,
  input  logic [ADDR_W-1:0]  ds_tgt_i,
  input  logic               blk_set_i,
  input  logic [STAGE_W-1:0] blk_stage_i,
  input  logic               sq_acc_i,
  input  logic [ADDR_W-1:0]  sq_pc_i,
  input  logic               act_i,
  input  logic [ADDR_W-1:0]  act_pc_i,
  input  logic               deact_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [SEQ_W-1:0]   seq_o,
  output logic               unblk_o,
  output logic [STAGE_W-1:0] unblk_stage_o
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INST_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INST_BYTES);
  localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3 * INST_BYTES);

  logic [ADDR_W-1:0]  pc_q, npc_q, nnpc_q, tgt_q;
  logic [ADDR_W-1:0]  pc_d, npc_d, nnpc_d, tgt_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               rdy_q, rdy_d, valid_q, valid_d;
  logic [STAGE_W-1:0] bstg_q, bstg_d;
  logic [SEQ_W-1:0]   seq_q, seq_d;
  logic               redir;

  assign redir         = rdy_q && (cnt_q == '0);
  assign pc_o          = redir ? tgt_q : pc_q;
  assign valid_o       = valid_q;
  assign seq_o         = seq_q;
  assign unblk_o       = sq_acc_i && !valid_q;
  assign unblk_stage_o = bstg_q;

  always_comb begin
    pc_d    = pc_q;
    npc_d   = npc_q;
    nnpc_d  = nnpc_q;
    tgt_d   = tgt_q;
    cnt_d   = cnt_q;
    rdy_d   = rdy_q;
    valid_d = valid_q;
    bstg_d  = bstg_q;
    seq_d   = seq_q;
    if (gnt_i) begin
      seq_d = seq_q + SEQ_W'(1);
      if (redir) begin
        pc_d   = tgt_q + STEP1;
        npc_d  = tgt_q + STEP2;
        nnpc_d = tgt_q + STEP3;
        rdy_d  = 1'b0;
      end else begin
        pc_d   = npc_q;
        npc_d  = nnpc_q;
        nnpc_d = nnpc_q + STEP1;
      end
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) rdy_d = 1'b1;
      end
    end
    // control update applies after the grant of the same cycle
    if (ds_set_i) begin
      cnt_d = cnt_d + CNT_W'(1);
      rdy_d = 1'b0;
      tgt_d = ds_tgt_i;
    end
    if (blk_set_i) begin
      valid_d = 1'b0;
      bstg_d  = blk_stage_i;
    end
    if (sq_acc_i) begin
      pc_d    = sq_pc_i;
      npc_d   = sq_pc_i + STEP1;
      nnpc_d  = sq_pc_i + STEP2;
      cnt_d   = '0;
      rdy_d   = 1'b0;
      valid_d = 1'b1;
    end
    if (act_i) begin
      pc_d    = act_pc_i;
      npc_d   = act_pc_i + STEP1;
      nnpc_d  = act_pc_i + STEP2;
      cnt_d   = '0;
      rdy_d   = 1'b0;
      valid_d = 1'b1;
    end
    if (deact_i) begin
      cnt_d   = '0;
      rdy_d   = 1'b0;
      valid_d = 1'b0;
      bstg_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      npc_q   <= '0;
      nnpc_q  <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
      rdy_q   <= 1'b0;
      valid_q <= 1'b0;
      bstg_q  <= '0;
      seq_q   <= '0;
    end else begin
      pc_q    <= pc_d;
      npc_q   <= npc_d;
      nnpc_q  <= nnpc_d;
      tgt_q   <= tgt_d;
      cnt_q   <= cnt_d;
      rdy_q   <= rdy_d;
      valid_q <= valid_d;
      bstg_q  <= bstg_d;
      seq_q   <= seq_d;
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fseq_pkg::*;
#(
  parameter int N_THREADS  = 2,
  parameter int N_SQ       = 2,
  parameter int ADDR_W     = 32,
  parameter int SEQ_W      = 16,
  parameter int STAGE_W    = 3,
  parameter int CNT_W      = 2,
  parameter int INST_BYTES = 4,
  localparam int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fetch_req_i,
  input  logic [TID_W-1:0]            fetch_tid_i,
  output logic                        fetch_gnt_o,
  output logic [ADDR_W-1:0]           fetch_pc_o,
  output logic [SEQ_W-1:0]            fetch_seq_o,
  input  logic                        ctl_valid_i,
  input  logic [TID_W-1:0]            ctl_tid_i,
  input  logic                        ctl_is_ctrl_i,
  input  logic                        ctl_is_ret_i,
  input  logic                        ctl_is_cond_ds_i,
  input  logic                        ctl_pred_taken_i,
  input  logic [ADDR_W-1:0]           ctl_pc_i,
  input  logic [ADDR_W-1:0]           ctl_target_i,
  input  logic [SEQ_W-1:0]            ctl_seq_i,
  input  logic [STAGE_W-1:0]          ctl_stage_i,
  output logic                        blk_valid_o,
  output logic [TID_W-1:0]            blk_tid_o,
  output logic [STAGE_W-1:0]          blk_stage_o,
  output logic                        csq_valid_o,
  output logic [TID_W-1:0]            csq_tid_o,
  output logic [SEQ_W-1:0]            csq_seq_o,
  input  logic [N_SQ-1:0]             sq_valid_i,
  input  logic [N_SQ*TID_W-1:0]       sq_tid_i,
  input  logic [N_SQ*SEQ_W-1:0]       sq_seq_i,
  input  logic [N_SQ*ADDR_W-1:0]      sq_pc_i,
  output logic [N_THREADS-1:0]        unblk_o,
  output logic [N_THREADS*STAGE_W-1:0] unblk_stage_o,
  input  logic                        act_valid_i,
  input  logic [TID_W-1:0]            act_tid_i,
  input  logic [ADDR_W-1:0]           act_pc_i,
  input  logic                        deact_valid_i,
  input  logic [TID_W-1:0]            deact_tid_i
);
  ctl_kind_e         kind;
  logic [ADDR_W-1:0] ds_tgt;

  logic [N_THREADS-1:0] thr_valid;
  logic [ADDR_W-1:0]    thr_pc  [N_THREADS];
  logic [SEQ_W-1:0]     thr_seq [N_THREADS];

  fseq_ctl_dec #(
    .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .INST_BYTES(INST_BYTES)
  ) u_dec (
    .valid_i   (ctl_valid_i),
    .is_ctrl_i (ctl_is_ctrl_i),
    .is_ret_i  (ctl_is_ret_i),
    .is_cond_i (ctl_is_cond_ds_i),
    .taken_i   (ctl_pred_taken_i),
    .pc_i      (ctl_pc_i),
    .target_i  (ctl_target_i),
    .seq_i     (ctl_seq_i),
    .kind_o    (kind),
    .tgt_o     (ds_tgt),
    .csq_o     (csq_valid_o),
    .csq_seq_o (csq_seq_o)
  );

  assign csq_tid_o   = ctl_tid_i;
  assign blk_valid_o = (kind == CK_STALL);
  assign blk_tid_o   = ctl_tid_i;
  assign blk_stage_o = ctl_stage_i;

  assign fetch_gnt_o = fetch_req_i && thr_valid[fetch_tid_i];
  assign fetch_pc_o  = thr_pc[fetch_tid_i];
  assign fetch_seq_o = thr_seq[fetch_tid_i];

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    logic              sq_acc;
    logic [ADDR_W-1:0] sq_pc;

    fseq_sq_arb #(
      .N_SQ(N_SQ), .TID_W(TID_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .THREAD(t)
    ) u_arb (
      .sq_valid_i (sq_valid_i),
      .sq_tid_i   (sq_tid_i),
      .sq_seq_i   (sq_seq_i),
      .sq_pc_i    (sq_pc_i),
      .acc_o      (sq_acc),
      .pc_o       (sq_pc)
    );

    fseq_thread #(
      .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .STAGE_W(STAGE_W),
      .CNT_W(CNT_W), .INST_BYTES(INST_BYTES)
    ) u_thr (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .gnt_i         (fetch_gnt_o && fetch_tid_i == TID_W'(t)),
      .ds_set_i      (kind == CK_DELAY && ctl_tid_i == TID_W'(t)),
      .ds_tgt_i      (ds_tgt),
      .blk_set_i     (kind == CK_STALL && ctl_tid_i == TID_W'(t)),
      .blk_stage_i   (ctl_stage_i),
      .sq_acc_i      (sq_acc),
      .sq_pc_i       (sq_pc),
      .act_i         (act_valid_i && act_tid_i == TID_W'(t)),
      .act_pc_i      (act_pc_i),
      .deact_i       (deact_valid_i && deact_tid_i == TID_W'(t)),
      .valid_o       (thr_valid[t]),
      .pc_o          (thr_pc[t]),
      .seq_o         (thr_seq[t]),
      .unblk_o       (unblk_o[t]),
      .unblk_stage_o (unblk_stage_o[t*STAGE_W +: STAGE_W])
    );
  end
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int N_THREADS = 2,
  parameter int N_SQ      = 2,
  parameter int ADDR_W    = 32,
  parameter int SEQ_W     = 16,
  parameter int STAGE_W   = 3,
  parameter int TID_W     = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fetch_req_i,
  input logic [TID_W-1:0]     fetch_tid_i,
  input logic                 fetch_gnt_o,
  input logic [ADDR_W-1:0]    fetch_pc_o,
  input logic [SEQ_W-1:0]     fetch_seq_o,
  input logic                 ctl_valid_i,
  input logic [TID_W-1:0]     ctl_tid_i,
  input logic                 ctl_is_ctrl_i,
  input logic                 ctl_is_ret_i,
  input logic                 ctl_is_cond_ds_i,
  input logic                 ctl_pred_taken_i,
  input logic [SEQ_W-1:0]     ctl_seq_i,
  input logic [STAGE_W-1:0]   ctl_stage_i,
  input logic                 blk_valid_o,
  input logic [STAGE_W-1:0]   blk_stage_o,
  input logic                 csq_valid_o,
  input logic [SEQ_W-1:0]     csq_seq_o,
  input logic [N_SQ-1:0]      sq_valid_i,
  input logic [N_THREADS-1:0] unblk_o,
  input logic                 act_valid_i,
  input logic [TID_W-1:0]     act_tid_i,
  input logic [ADDR_W-1:0]    act_pc_i,
  input logic                 deact_valid_i,
  input logic [TID_W-1:0]     deact_tid_i
);
  logic ret_unpred, cond_nt, taken_ctl;
  assign ret_unpred = ctl_valid_i && ctl_is_ctrl_i && ctl_is_ret_i && !ctl_pred_taken_i;
  assign cond_nt    = ctl_valid_i && ctl_is_ctrl_i && !ctl_is_ret_i &&
                      ctl_is_cond_ds_i && !ctl_pred_taken_i;
  assign taken_ctl  = ctl_valid_i && ctl_is_ctrl_i && ctl_pred_taken_i;

  p_act_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_i && !(deact_valid_i && deact_tid_i == act_tid_i)
    |=> !(fetch_req_i && fetch_tid_i == $past(act_tid_i)) ||
        (fetch_gnt_o && fetch_pc_o == $past(act_pc_i)));

  p_gnt_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_gnt_o |-> fetch_req_i);

  p_seq_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fetch_gnt_o) && fetch_gnt_o && fetch_tid_i == $past(fetch_tid_i)
    |-> fetch_seq_o == $past(fetch_seq_o) + SEQ_W'(1));

  p_taken_csq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_ctl |-> csq_valid_o && csq_seq_o == ctl_seq_i + SEQ_W'(1));

  p_ret_blk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_unpred |-> blk_valid_o && blk_stage_o == ctl_stage_i);

  p_ret_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_unpred && sq_valid_i == '0 && !act_valid_i
    |=> !(fetch_gnt_o && fetch_tid_i == $past(ctl_tid_i)));

  p_cond_csq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_nt |-> csq_valid_o && csq_seq_o == ctl_seq_i);

  p_nonctrl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_valid_i && !ctl_is_ctrl_i |-> !csq_valid_o && !blk_valid_o);

  p_unblk_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unblk_o != '0 |-> sq_valid_i != '0);

  p_deact_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_valid_i |=> !(fetch_gnt_o && fetch_tid_i == $past(deact_tid_i)));
endmodule

bind fetch_seq fetch_seq_chk #(
  .N_THREADS(N_THREADS), .N_SQ(N_SQ), .ADDR_W(ADDR_W),
  .SEQ_W(SEQ_W), .STAGE_W(STAGE_W), .TID_W(TID_W)
) u_chk (.*);

// File: tb/tb_fetch_seq.sv
module tb_fetch_seq;
  localparam int NT = 2, NSQ = 2, AW = 32, SW = 16, STW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic fetch_req_i, fetch_gnt_o;
  logic [0:0] fetch_tid_i;
  logic [AW-1:0] fetch_pc_o;
  logic [SW-1:0] fetch_seq_o;
  logic ctl_valid_i, ctl_is_ctrl_i, ctl_is_ret_i, ctl_is_cond_ds_i, ctl_pred_taken_i;
  logic [0:0] ctl_tid_i;
  logic [AW-1:0] ctl_pc_i, ctl_target_i;
  logic [SW-1:0] ctl_seq_i;
  logic [STW-1:0] ctl_stage_i;
  logic blk_valid_o, csq_valid_o;
  logic [0:0] blk_tid_o, csq_tid_o;
  logic [STW-1:0] blk_stage_o;
  logic [SW-1:0] csq_seq_o;
  logic [NSQ-1:0] sq_valid_i;
  logic [NSQ-1:0] sq_tid_i;
  logic [NSQ*SW-1:0] sq_seq_i;
  logic [NSQ*AW-1:0] sq_pc_i;
  logic [NT-1:0] unblk_o;
  logic [NT*STW-1:0] unblk_stage_o;
  logic act_valid_i, deact_valid_i;
  logic [0:0] act_tid_i, deact_tid_i;
  logic [AW-1:0] act_pc_i;

  fetch_seq dut (.*);

  int total = 0, bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_req_i = 0; fetch_tid_i = 0;
    ctl_valid_i = 0; ctl_tid_i = 0; ctl_is_ctrl_i = 0; ctl_is_ret_i = 0;
    ctl_is_cond_ds_i = 0; ctl_pred_taken_i = 0; ctl_pc_i = 0; ctl_target_i = 0;
    ctl_seq_i = 0; ctl_stage_i = 0;
    sq_valid_i = 0; sq_tid_i = 0; sq_seq_i = 0; sq_pc_i = 0;
    act_valid_i = 0; act_tid_i = 0; act_pc_i = 0;
    deact_valid_i = 0; deact_tid_i = 0;
  endtask

  task automatic step();
    @(negedge clk_i);
    idle();
  endtask

  task automatic fetch(logic tid, logic [31:0] epc, logic [15:0] eseq, string req);
    fetch_req_i = 1; fetch_tid_i = tid;
    #1;
    chk({req, " gnt"}, 32'(fetch_gnt_o), 32'd1);
    chk({req, " pc"}, fetch_pc_o, epc);
    chk({req, " seq"}, 32'(fetch_seq_o), 32'(eseq));
    step();
  endtask

  task automatic ctl(logic tid, logic [3:0] fl, logic [31:0] pc, logic [31:0] tgt,
                     logic [15:0] seq, logic [2:0] stg);
    ctl_valid_i = 1; ctl_tid_i = tid;
    {ctl_is_ctrl_i, ctl_is_ret_i, ctl_is_cond_ds_i, ctl_pred_taken_i} = fl;
    ctl_pc_i = pc; ctl_target_i = tgt; ctl_seq_i = seq; ctl_stage_i = stg;
  endtask

  // op: 1 activate, 2 fetch, 3 control; fl = {ctrl, ret, cond, taken}
  typedef struct packed {
    logic [1:0]  op;
    logic        tid;
    logic [3:0]  fl;
    logic [31:0] addr;
    logic [2:0]  stg;
    logic        eg;
    logic [31:0] epc;
    logic [15:0] eseq;
  } vec_t;

  localparam vec_t TBL [17] = '{
    '{2'd1, 1'b0, 4'h0, 32'h100,  3'd0, 1'b0, 32'h0,   16'd0}, // R1 act t0
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h100, 16'd0}, // R1 R4
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h104, 16'd1}, // R1 R2
    '{2'd3, 1'b0, 4'h9, 32'h200,  3'd0, 1'b0, 32'h0,   16'd0}, // R5 taken -> 0x200
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h108, 16'd2}, // R5 slot
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h200, 16'd3}, // R5 redirect
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h204, 16'd4}, // R2
    '{2'd3, 1'b0, 4'h8, 32'h204,  3'd0, 1'b0, 32'h0,   16'd0}, // R5 not-taken at 0x204
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h208, 16'd5}, // R5 slot
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h20C, 16'd6}, // R5 fall-through
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h210, 16'd7}, // R2
    '{2'd1, 1'b1, 4'h0, 32'h4000, 3'd0, 1'b0, 32'h0,   16'd0}, // R1 act t1
    '{2'd2, 1'b1, 4'h0, 32'h0,    3'd0, 1'b1, 32'h4000,16'd0}, // R4 own counter
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b1, 32'h214, 16'd8}, // R4
    '{2'd3, 1'b0, 4'hC, 32'h0,    3'd3, 1'b0, 32'h0,   16'd0}, // R6 return
    '{2'd2, 1'b0, 4'h0, 32'h0,    3'd0, 1'b0, 32'h0,   16'd0}, // R3 R6 stall
    '{2'd2, 1'b1, 4'h0, 32'h0,    3'd0, 1'b1, 32'h4004,16'd1}  // R4 other thread runs
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 reset state
    fetch_req_i = 1; fetch_tid_i = 0; #1;
    chk("R12 gnt t0", 32'(fetch_gnt_o), 0);
    fetch_tid_i = 1; #1;
    chk("R12 gnt t1", 32'(fetch_gnt_o), 0);
    chk("R12 blk", 32'(blk_valid_o), 0);
    chk("R12 csq", 32'(csq_valid_o), 0);
    chk("R12 unblk", 32'(unblk_o), 0);
    step();

    for (int i = 0; i < 17; i++) begin
      case (TBL[i].op)
        2'd1: begin act_valid_i = 1; act_tid_i = TBL[i].tid; act_pc_i = TBL[i].addr; end
        2'd2: begin fetch_req_i = 1; fetch_tid_i = TBL[i].tid; end
        2'd3: ctl(TBL[i].tid, TBL[i].fl, TBL[i].addr, TBL[i].addr, 16'd0, TBL[i].stg);
        default: ;
      endcase
      #1;
      chk($sformatf("table %0d gnt", i), 32'(fetch_gnt_o), 32'(TBL[i].eg));
      if (TBL[i].eg) begin
        chk($sformatf("table %0d pc", i), fetch_pc_o, TBL[i].epc);
        chk($sformatf("table %0d seq", i), 32'(fetch_seq_o), 32'(TBL[i].eseq));
      end
      if (TBL[i].op == 2'd3 && TBL[i].fl == 4'hC) begin
        chk("R6 blk_valid", 32'(blk_valid_o), 1);
        chk("R6 blk_stage", 32'(blk_stage_o), 3);
      end
      step();
    end

    // R9 R10: two lanes on stalled t0, lane1 older
    sq_valid_i = 2'b11; sq_tid_i = 2'b00;
    sq_seq_i = {16'd15, 16'd20}; sq_pc_i = {32'h380, 32'h300};
    #1;
    chk("R10 unblk", 32'(unblk_o), 32'b01);
    chk("R10 unblk_stage", 32'(unblk_stage_o[2:0]), 3);
    step();
    fetch(0, 32'h380, 16'd9, "R9 oldest lane / R3 seq kept");
    // R9 tie -> lane 0
    sq_valid_i = 2'b11; sq_tid_i = 2'b00;
    sq_seq_i = {16'd30, 16'd30}; sq_pc_i = {32'h600, 32'h500};
    #1;
    chk("R10 no unblk when valid", 32'(unblk_o), 0);
    step();
    fetch(0, 32'h500, 16'd10, "R9 tie");

    // R7 conditional not-taken
    ctl(0, 4'hA, 32'h500, 32'h800, 16'd40, 3'd2); #1;
    chk("R7 csq_valid", 32'(csq_valid_o), 1);
    chk("R7 csq_seq", 32'(csq_seq_o), 40);
    chk("R7 blk", 32'(blk_valid_o), 0);
    step();
    fetch(0, 32'h504, 16'd11, "R7 window kept");

    // R8 non-control
    ctl(0, 4'h1, 32'h504, 32'h900, 16'd50, 3'd2); #1;
    chk("R8 csq", 32'(csq_valid_o), 0);
    chk("R8 blk", 32'(blk_valid_o), 0);
    step();
    fetch(0, 32'h508, 16'd12, "R8 no redirect");
    fetch(0, 32'h50C, 16'd13, "R8 no redirect");

    // R5 taken squash request, then R11 drops armed slot
    ctl(0, 4'h9, 32'h50C, 32'hA00, 16'd60, 3'd2); #1;
    chk("R5 csq_valid", 32'(csq_valid_o), 1);
    chk("R5 csq_seq", 32'(csq_seq_o), 61);
    step();
    deact_valid_i = 1; deact_tid_i = 0; step();
    fetch_req_i = 1; fetch_tid_i = 0; #1;
    chk("R11 gnt after deact", 32'(fetch_gnt_o), 0);
    step();
    act_valid_i = 1; act_tid_i = 0; act_pc_i = 32'h700; step();
    fetch(0, 32'h700, 16'd14, "R11 reactivate");
    fetch(0, 32'h704, 16'd15, "R11 no stale redirect");

    // R2 wrap
    act_valid_i = 1; act_tid_i = 1; act_pc_i = 32'hFFFF_FFFC; step();
    fetch(1, 32'hFFFF_FFFC, 16'd2, "R2 wrap a");
    fetch(1, 32'h0, 16'd3, "R2 wrap b");

    // R10 squash clears armed delay slot
    ctl(1, 4'h9, 32'h0, 32'hB00, 16'd70, 3'd1); step();
    sq_valid_i = 2'b10; sq_tid_i = 2'b10;
    sq_seq_i = {16'd5, 16'd0}; sq_pc_i = {32'hC00, 32'h0}; step();
    fetch(1, 32'hC00, 16'd4, "R10 reload");
    fetch(1, 32'hC04, 16'd5, "R10 delay cleared");
    fetch(1, 32'hC08, 16'd6, "R10 delay cleared");

    // R11 stage reset, R9 per-thread lanes
    deact_valid_i = 1; deact_tid_i = 1; step();
    sq_valid_i = 2'b11; sq_tid_i = 2'b10;
    sq_seq_i = {16'd1, 16'd100}; sq_pc_i = {32'hE00, 32'hD00};
    #1;
    chk("R11 unblk t1", 32'(unblk_o[1]), 1);
    chk("R11 blk stage cleared", 32'(unblk_stage_o[5:3]), 0);
    step();
    fetch(0, 32'hD00, 16'd16, "R9 per thread t0");
    fetch(1, 32'hE00, 16'd7, "R9 per thread t1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule